// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block is the arithmetic core of a small accumulator machine. It holds a local register file made of one accumulator, three auxiliary registers and a flag register, all W bits wide. It also holds an adder/subtractor and a single-position logical shifter. The control sequencer issues one command per clock on a plain 5-bit command input. A data word that the sequencer has already fetched from memory or an input port arrives alongside the command. The accumulator value and the status word go straight back to the sequencer.

Each command finishes in one clock, so the block applies no back-pressure and has no valid/ready pairing. A command takes effect on the rising edge where it is presented, and the result appears on the outputs right after that edge. Arithmetic and shift commands always pair the accumulator with one auxiliary register, or with the accumulator's own bits for a shift. Every command that writes the accumulator also rewrites the status word. Loading an auxiliary register leaves the status word alone.

The command splits into two fields. Bits [4:2] give the operation: 0 hold, 1 add, 2 subtract, 3 load accumulator, 4 load auxiliary, 5 shift left, 6 shift right, 7 hold. Bits [1:0] pick the auxiliary register: 1, 2 or 3 name that register, and 0 stands for register 1 on add and subtract.

Top module: `acc_alu`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the accumulator, all three auxiliary registers and every flag bit clear to 0 on the next rising edge. The zero flag is also 0 after reset.
- R2: Add (op 1) sets the accumulator to (accumulator + selected auxiliary) mod 2^W, and the carry flag to the carry out of bit W-1.
- R3: Subtract (op 2) sets the accumulator to (accumulator − selected auxiliary) mod 2^W, and the carry flag to 1 exactly when the auxiliary value is greater, unsigned, than the old accumulator (a borrow).
- R4: Load accumulator (op 3) copies `din` into the accumulator and clears the carry flag.
- R5: Load auxiliary (op 4) with select 1, 2 or 3 copies `din` into that auxiliary register and changes neither the accumulator nor the flags. With select 0 it changes nothing.
- R6: Shift left (op 5) and shift right (op 6) move the accumulator one position, fill with 0, and place the bit shifted out in the carry flag.
- R7: After every accumulator-writing command (ops 1, 2, 3, 5, 6), flag bit 0 (zero) is 1 exactly when the new accumulator is all zeros.
- R8: After every accumulator-writing command, flag bit 1 (sign) equals bit W-1 of the new accumulator.
- R9: After every accumulator-writing command, flag bit 2 (parity) is 1 exactly when the new accumulator holds an odd number of ones.
- R10: Ops 0 and 7 leave the accumulator, the flags and the auxiliary registers unchanged.
- R11: Flag bits W-1 down to 4 are always 0. Flag bit 3 is the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 5 | Operation in [4:2], auxiliary select in [1:0] |
| din | input | W | Word fetched by the sequencer |
| acc_o | output | W | Accumulator contents |
| flags_o | output | W | Status word: [0] zero, [1] sign, [2] parity, [3] carry, upper bits 0 |

## Verification
The directed patterns each isolate one effect:
- An add from 0x01 with 0x7F makes the sign flip without a carry.
- An add of 0xFF to 0x01 wraps to zero with a carry.
- A subtract of a larger auxiliary value produces a borrow.
- Shifts of 0x81 and 0x01 push a 1 into the carry from each end.

Loading the auxiliary registers with distinct values and then adding from each select tells select 0, 1, 2 and 3 apart. A long pseudo-random command stream mixes loads, holds and arithmetic. Across that stream, a flag computed from the wrong value or a stale register shows up against the cycle-by-cycle model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_LDA  = 3'd3,
    OP_LDX  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_IDLE = 3'd7
  } op_e;

  localparam int FLG_Z = 0;
  localparam int FLG_S = 1;
  localparam int FLG_P = 2;
  localparam int FLG_C = 3;
  localparam int FLG_N = 4;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cy
);
  localparam int EW = W + 1;
  logic [EW-1:0] wide;

  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b};
    else     wide = {1'b0, a} + {1'b0, b};
    res = wide[W-1:0];
    cy  = wide[EW-1];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         right,
  output logic [W-1:0] res,
  output logic         out_bit
);
  always_comb begin
    if (right) begin
      res     = {1'b0, a[W-1:1]};
      out_bit = a[0];
    end else begin
      res     = {a[W-2:0], 1'b0};
      out_bit = a[W-1];
    end
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         cy,
  output logic [W-1:0] flags
);
  import acc_alu_pkg::*;

  always_comb begin
    flags        = '0;
    flags[FLG_Z] = (val == '0);
    flags[FLG_S] = val[W-1];
    flags[FLG_P] = ^val;
    flags[FLG_C] = cy;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [4:0]   cmd,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] flags_o
);
  import acc_alu_pkg::*;

  localparam int NAUX = 3;
  localparam int SELW = 2;

  op_e             op;
  logic [SELW-1:0] sel;
  logic [W-1:0]    acc_q, flag_q;
  logic [W-1:0]    aux_q [NAUX];
  logic [W-1:0]    operand;
  logic [W-1:0]    as_res, sh_res, acc_nxt, flag_nxt;
  logic            as_cy, sh_cy, cy_nxt, acc_we;

  assign op  = op_e'(cmd[4:2]);
  assign sel = cmd[1:0];

  always_comb begin
    case (sel)
      2'd2:    operand = aux_q[1];
      2'd3:    operand = aux_q[2];
      default: operand = aux_q[0];
    endcase
  end

  alu_addsub #(.W(W)) u_as (
    .a(acc_q), .b(operand), .sub(op == OP_SUB), .res(as_res), .cy(as_cy)
  );

  alu_shift #(.W(W)) u_sh (
    .a(acc_q), .right(op == OP_SHR), .res(sh_res), .out_bit(sh_cy)
  );

  always_comb begin
    acc_we  = 1'b1;
    acc_nxt = acc_q;
    cy_nxt  = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin acc_nxt = as_res; cy_nxt = as_cy; end
      OP_LDA:         begin acc_nxt = din;    cy_nxt = 1'b0;  end
      OP_SHL, OP_SHR: begin acc_nxt = sh_res; cy_nxt = sh_cy; end
      default:        acc_we = 1'b0;
    endcase
  end

  alu_flags #(.W(W)) u_fl (.val(acc_nxt), .cy(cy_nxt), .flags(flag_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flag_q <= '0;
    end else if (acc_we) begin
      acc_q  <= acc_nxt;
      flag_q <= flag_nxt;
    end
  end

  for (genvar g = 0; g < NAUX; g++) begin : g_aux
    always_ff @(posedge clk) begin
      if (rst)
        aux_q[g] <= '0;
      else if (op == OP_LDX && sel == SELW'(g + 1))
        aux_q[g] <= din;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flag_q;

  // Assertions, each guarding the register update above.
  p_lda_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LDA) |=> (acc_o == $past(din)) && !flags_o[FLG_C]);

  p_ldx_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LDX) |=> $stable(acc_o) && $stable(flags_o));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD || op == OP_IDLE) |=> $stable(acc_o) && $stable(flags_o));

  p_zero_r7: assert property (@(posedge clk) disable iff (rst)
    acc_we |=> (flags_o[FLG_Z] == (acc_o == '0)));

  p_sign_r8: assert property (@(posedge clk) disable iff (rst)
    acc_we |=> (flags_o[FLG_S] == acc_o[W-1]));

  p_parity_r9: assert property (@(posedge clk) disable iff (rst)
    acc_we |=> (flags_o[FLG_P] == ($countones(acc_o) % 2 == 1)));

  p_shl_r6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHL) |=> (flags_o[FLG_C] == $past(acc_o[W-1])) && !acc_o[0]);

  p_upper_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags_o[W-1:FLG_N] == '0));
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4:0]   cmd = '0;
  logic [W-1:0] din = '0;
  logic [W-1:0] acc_o, flags_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  int m_acc, m_flg;
  int m_rx[4];
  string last_tag = "R1";

  acc_alu #(.W(W)) u0 (.clk(clk), .rst(rst), .cmd(cmd), .din(din),
                       .acc_o(acc_o), .flags_o(flags_o));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: got cycle %0d expected finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int mkflags(int a, int c);
    int f = 0;
    if (a == 0) f += 1;                       // R7
    if (a >= M / 2) f += 2;                   // R8
    if ($countones(a[W-1:0]) % 2 == 1) f += 4; // R9
    if (c != 0) f += 8;                       // R11 carry position
    return f;
  endfunction

  task automatic compare();
    total++;
    if (acc_o !== W'(m_acc)) begin
      bad++;
      $display("FAIL %s acc got %h expected %h", last_tag, acc_o, W'(m_acc));
    end
    total++;
    if (flags_o !== W'(m_flg)) begin
      bad++;
      $display("FAIL %s R7 R8 R9 R11 flags got %h expected %h", last_tag, flags_o, W'(m_flg));
    end
  endtask

  // Apply one command at a falling edge; check results at the next falling edge.
  task automatic step(int op, int sel, int d);
    int r, v, c;
    cmd = 5'(op * 4 + sel);
    din = W'(d);
    r = m_rx[(sel == 0) ? 1 : sel];
    case (op)
      1: begin v = m_acc + r; c = (v >= M); v = v % M;
               m_acc = v; m_flg = mkflags(v, c); last_tag = "R2"; end
      2: begin c = (r > m_acc); v = (m_acc - r + M) % M;
               m_acc = v; m_flg = mkflags(v, c); last_tag = "R3"; end
      3: begin m_acc = d; m_flg = mkflags(d, 0); last_tag = "R4"; end
      4: begin if (sel != 0) m_rx[sel] = d; last_tag = "R5"; end
      5: begin c = m_acc / (M / 2); v = (m_acc * 2) % M;
               m_acc = v; m_flg = mkflags(v, c); last_tag = "R6"; end
      6: begin c = m_acc % 2; v = m_acc / 2;
               m_acc = v; m_flg = mkflags(v, c); last_tag = "R6"; end
      default: last_tag = "R10";
    endcase
    @(negedge clk);
    compare();
  endtask

  initial begin
    m_acc = 0; m_flg = 0;
    for (int i = 0; i < 4; i++) m_rx[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare(); // R1 reset state
    // R1: aux registers cleared, observed by adding each one to zero
    step(1, 1, 0); step(1, 2, 0); step(1, 3, 0);
    // R2 sign turns on without carry
    step(3, 0, 8'h01); step(4, 1, 8'h7F); step(1, 1, 0);
    // R2 wrap to zero with carry
    step(3, 0, 8'h01); step(4, 1, 8'hFF); step(1, 0, 0);
    // R3 borrow
    step(3, 0, 8'h03); step(4, 2, 8'h05); step(2, 2, 0);
    step(2, 2, 0);
    // R5 select 0 load has no effect; R10 holds
    step(4, 0, 8'hAA); step(1, 0, 0);
    step(0, 1, 8'h55); step(7, 3, 8'h55);
    // R5 distinct selects told apart
    step(4, 3, 8'h10); step(3, 0, 0); step(1, 3, 0); step(1, 2, 0);
    // R6 shifts
    step(3, 0, 8'h81); step(5, 0, 0); step(3, 0, 8'h01); step(6, 0, 0);
    step(6, 0, 0);
    // R9 parity patterns
    step(3, 0, 8'h07); step(3, 0, 8'h0F);
    // mixed pseudo-random stream
    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, M - 1)));
    // R1 reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_flg = 0; last_tag = "R1";
    for (int i = 0; i < 4; i++) m_rx[i] = 0;
    compare();
    step(1, 3, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule